// File: doc/BRIEF.md
# Masked Binary Content-Addressable Memory

This block is a small static binary search memory. It holds `ENTRIES` words of `WIDTH` bits, and each word has a flag that marks it as in use. Software-free control logic loads a search key into a key register and a bit-select pattern into a mask register, writes words by address, and retires words by address. A search command compares the key against every word at once. Only the bit positions selected by the mask are compared, and only words that are in use may match.

A responder turns the per-word match lines into a hit flag and the index of the lowest matching word. The result is registered and appears one clock after the search command. The per-word match vector is exported as well, so it can drive the word lines of a companion data RAM. A plain read port returns the stored word and its in-use flag at any address, as an ordinary RAM would.

All pins are plain level or strobe signals. The block never stalls: every command is taken in the cycle it is presented, so there is no back-pressure to manage.

Top module: `mcam_top`

## Requirements
- R1: Reset clears every in-use flag, drives `hit` low, `hit_idx` to 0 and `match_vec` to all zeros. The key register resets to 0 and the mask register resets to all ones, which means every bit is compared.
- R2: With `wr_en` high at a clock edge, `wr_data` is stored at `wr_idx` and that word is marked in use. Both show on the read port from the next cycle.
- R3: With `retire_en` high at a clock edge, the word at `retire_idx` is marked not in use and can no longer match. If a write targets the same index in the same cycle, the write wins and the word stays in use.
- R4: With `search_go` high at a clock edge, bit i of `match_vec` becomes 1 on that edge exactly when word i is in use and equals the key on every position whose mask bit is 1.
- R5: A mask bit of 0 removes that position from every compare. An all-zero mask matches every word in use.
- R6: When more than one word matches, `match_vec` shows all of them and `hit_idx` gives the lowest matching index.
- R7: When no word matches, the search leaves `hit` = 0, `hit_idx` = 0 and `match_vec` = 0.
- R8: `hit`, `hit_idx` and `match_vec` keep their values until the next search, whatever key, mask, write or retire commands arrive in between.
- R9: A search sees the key, mask, words and in-use flags as they were before the edge. A key load, mask load or write issued in the same cycle as the search takes effect only for later searches.
- R10: `rd_data` and `rd_used` show, without a clock delay, the stored word and in-use flag at `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_ld | input | 1 | Load `key_in` into the key register |
| key_in | input | WIDTH | New search key |
| mask_ld | input | 1 | Load `mask_in` into the mask register |
| mask_in | input | WIDTH | New mask; 1 = compare the position, 0 = ignore it |
| wr_en | input | 1 | Write a word and mark it in use |
| wr_idx | input | $clog2(ENTRIES) | Write index |
| wr_data | input | WIDTH | Word to store |
| retire_en | input | 1 | Mark a word not in use |
| retire_idx | input | $clog2(ENTRIES) | Index to retire |
| search_go | input | 1 | Start a search; the result is registered on this edge |
| hit | output | 1 | At least one word matched on the last search |
| hit_idx | output | $clog2(ENTRIES) | Lowest matching index, or 0 on a miss |
| match_vec | output | ENTRIES | Per-word match lines from the last search |
| rd_idx | input | $clog2(ENTRIES) | Read port index |
| rd_data | output | WIDTH | Stored word at `rd_idx` |
| rd_used | output | 1 | In-use flag at `rd_idx` |

## Verification
The bench targets the cases where a faulty design gives a plausible but wrong answer. A duplicated word and overlapping masked patterns produce several matches; a priority encoder that picks the highest index, or the last one seen, would report the wrong address. A search issued in the same cycle as a key load or a write must use the old key and the old contents; a design that forwards the new values would report the new match one cycle early. A write and a retire to the same index in the same cycle must leave the word in use. The bench also checks that a mask reset to zero would match every word, and that outputs which are not held between searches would drift when unrelated commands arrive.

// File: rtl/mcam_store.sv
module mcam_store #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               retire_en,
  input  logic [IW-1:0]      retire_idx,
  input  logic [WIDTH-1:0]   key,
  input  logic [WIDTH-1:0]   mask,
  output logic [ENTRIES-1:0] match_raw,
  input  logic [IW-1:0]      rd_idx,
  output logic [WIDTH-1:0]   rd_data,
  output logic               rd_used
);

  logic [WIDTH-1:0]   words [ENTRIES];
  logic [ENTRIES-1:0] used_q;

  // word storage, no reset needed: the in-use flag guards it
  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  // in-use flags; a write overrides a retire of the same index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      if (retire_en) used_q[retire_idx] <= 1'b0;
      if (wr_en)     used_q[wr_idx]     <= 1'b1;
    end
  end

  // one masked comparator per word
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff         = (words[g] ^ key) & mask;
    assign match_raw[g] = used_q[g] && (diff == '0);
  end

  assign rd_data = words[rd_idx];
  assign rd_used = used_q[rd_idx];

  AST_WRITE_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> used_q[$past(wr_idx)]); // R2

  AST_WRITE_STORES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (words[$past(wr_idx)] == $past(wr_data))); // R2

  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retire_en) && !($past(wr_en) && $past(wr_idx) == $past(retire_idx)))
      |-> !used_q[$past(retire_idx)]); // R3

  AST_RETIRED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retire_en) && !($past(wr_en) && $past(wr_idx) == $past(retire_idx)))
      |-> !match_raw[$past(retire_idx)]); // R3

endmodule

// File: rtl/mcam_responder.sv
module mcam_responder #(
  parameter int ENTRIES = 16,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               search_go,
  input  logic [ENTRIES-1:0] match_raw,
  output logic               hit,
  output logic [IW-1:0]      hit_idx,
  output logic [ENTRIES-1:0] match_vec
);

  logic [IW-1:0] low_idx;

  // lowest set bit wins: scan downward so the last assignment is the lowest
  always_comb begin
    low_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_raw[i]) low_idx = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      match_vec <= '0;
    end else if (search_go) begin
      hit       <= |match_raw;
      hit_idx   <= low_idx;
      match_vec <= match_raw;
    end
  end

  AST_HIT_POINTS_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx]); // R6

  AST_HIT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0)); // R6

  AST_MISS_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && match_vec == '0)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(search_go) |-> ($stable(hit) && $stable(hit_idx) && $stable(match_vec))); // R8

endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_ld,
  input  logic [WIDTH-1:0]   key_in,
  input  logic               mask_ld,
  input  logic [WIDTH-1:0]   mask_in,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               retire_en,
  input  logic [IW-1:0]      retire_idx,
  input  logic               search_go,
  output logic               hit,
  output logic [IW-1:0]      hit_idx,
  output logic [ENTRIES-1:0] match_vec,
  input  logic [IW-1:0]      rd_idx,
  output logic [WIDTH-1:0]   rd_data,
  output logic               rd_used
);

  logic [WIDTH-1:0]   key_q;
  logic [WIDTH-1:0]   mask_q;
  logic [ENTRIES-1:0] match_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      mask_q <= '1;
    end else begin
      if (key_ld)  key_q  <= key_in;
      if (mask_ld) mask_q <= mask_in;
    end
  end

  mcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .retire_en  (retire_en),
    .retire_idx (retire_idx),
    .key        (key_q),
    .mask       (mask_q),
    .match_raw  (match_raw),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .rd_used    (rd_used)
  );

  mcam_responder #(.ENTRIES(ENTRIES)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .search_go (search_go),
    .match_raw (match_raw),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .match_vec (match_vec)
  );

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(key_ld) |-> (key_q == $past(key_in))); // R9

  AST_SEARCH_SEES_OLD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(search_go) && $past(match_raw) == '0) |-> (!hit && match_vec == '0)); // R7

  AST_VEC_FOLLOWS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(search_go) |-> (match_vec == $past(match_raw))); // R4

endmodule

// File: tb/sim_mcam_top.sv
module sim_mcam_top;
  localparam int N  = 16;
  localparam int W  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key_ld = 0, mask_ld = 0, wr_en = 0, retire_en = 0, search_go = 0;
  logic [W-1:0]  key_in = '0, mask_in = '0, wr_data = '0;
  logic [IW-1:0] wr_idx = '0, retire_idx = '0, rd_idx = '0;
  logic          hit, rd_used;
  logic [IW-1:0] hit_idx;
  logic [N-1:0]  match_vec;
  logic [W-1:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  mcam_top #(.ENTRIES(N), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .key_ld(key_ld), .key_in(key_in),
    .mask_ld(mask_ld), .mask_in(mask_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .retire_en(retire_en), .retire_idx(retire_idx),
    .search_go(search_go), .hit(hit), .hit_idx(hit_idx), .match_vec(match_vec),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_used(rd_used)
  );

  // {mask, key, hit, idx, vec} against contents 0:12 1:34 2:56 3:12 5:A5 15:FF
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {8'hFF, 8'h12, 1'b1, 4'd0,  16'h0009},  // R6 duplicate word
    {8'hFF, 8'h34, 1'b1, 4'd1,  16'h0002},  // R4 exact
    {8'hFF, 8'h77, 1'b0, 4'd0,  16'h0000},  // R7 miss
    {8'hF0, 8'h1F, 1'b1, 4'd0,  16'h0009},  // R5 upper nibble
    {8'h0F, 8'h05, 1'b1, 4'd5,  16'h0020},  // R5 lower nibble
    {8'h00, 8'h00, 1'b1, 4'd0,  16'h802F},  // R5 all masked
    {8'h80, 8'h80, 1'b1, 4'd5,  16'h8020},  // R6 bit 7 set
    {8'hFF, 8'hFF, 1'b1, 4'd15, 16'h8000},  // R4 top index
    {8'h0F, 8'h06, 1'b1, 4'd2,  16'h0004}   // R5 lower nibble
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(input int idx, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_and_search(input logic [W-1:0] m, input logic [W-1:0] k);
    @(negedge clk);
    mask_ld = 1; mask_in = m; key_ld = 1; key_in = k;
    @(negedge clk);
    mask_ld = 0; key_ld = 0; search_go = 1;
    @(negedge clk);
    search_go = 0;
  endtask

  task automatic search_only();
    @(negedge clk);
    search_go = 1;
    @(negedge clk);
    search_go = 0;
  endtask

  task automatic expect_result(input string req, input logic h, input int idx, input logic [N-1:0] v);
    check({req, " hit"}, 32'(hit), 32'(h));
    check({req, " idx"}, 32'(hit_idx), 32'(idx));
    check({req, " vec"}, 32'(match_vec), 32'(v));
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_result("R1 reset", 1'b0, 0, '0);
    rd_idx = 0;
    #1 check("R1 used flag cleared", 32'(rd_used), 32'd0);
    // R1 search with reset key/mask: nothing in use
    search_only();
    expect_result("R1 empty search", 1'b0, 0, '0);
    // R1 mask resets to all ones: key 0 hits only word 0x00, not 0x01
    write_word(0, 8'h00);
    write_word(1, 8'h01);
    search_only();
    expect_result("R1 reset mask", 1'b1, 0, 16'h0001);

    // content setup
    write_word(0, 8'h12);
    write_word(1, 8'h34);
    write_word(2, 8'h56);
    write_word(3, 8'h12);
    write_word(5, 8'hA5);
    write_word(15, 8'hFF);
    // R2 / R10 read port
    rd_idx = 5;
    #1 check("R10 read data", 32'(rd_data), 32'hA5);
    check("R2 used after write", 32'(rd_used), 32'd1);
    rd_idx = 4;
    #1 check("R10 unused flag", 32'(rd_used), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      load_and_search(VEC[i][36:29], VEC[i][28:21]);
      expect_result($sformatf("R4 vector %0d", i), VEC[i][20], int'(VEC[i][19:16]), VEC[i][15:0]);
    end

    // R3 retire word 0, search for 12 now finds only word 3
    @(negedge clk);
    retire_en = 1; retire_idx = 0;
    @(negedge clk);
    retire_en = 0;
    load_and_search(8'hFF, 8'h12);
    expect_result("R3 retired word", 1'b1, 3, 16'h0008);
    // R3 write and retire same index same cycle: write wins
    @(negedge clk);
    wr_en = 1; wr_idx = 4; wr_data = 8'h99; retire_en = 1; retire_idx = 4;
    @(negedge clk);
    wr_en = 0; retire_en = 0;
    rd_idx = 4;
    #1 check("R3 write beats retire", 32'(rd_used), 32'd1);
    check("R3 write data", 32'(rd_data), 32'h99);

    // R8 hold: unrelated commands without a search
    @(negedge clk);
    key_ld = 1; key_in = 8'hFF; mask_ld = 1; mask_in = 8'hFF;
    wr_en = 1; wr_idx = 7; wr_data = 8'h3C;
    @(negedge clk);
    key_ld = 0; mask_ld = 0; wr_en = 0;
    retire_en = 1; retire_idx = 3;
    @(negedge clk);
    retire_en = 0;
    repeat (2) @(negedge clk);
    expect_result("R8 held", 1'b1, 3, 16'h0008);

    // R9 key load in the search cycle: old key FF used
    @(negedge clk);
    key_ld = 1; key_in = 8'h34; search_go = 1;
    @(negedge clk);
    key_ld = 0; search_go = 0;
    expect_result("R9 old key", 1'b1, 15, 16'h8000);
    search_only();
    expect_result("R9 new key", 1'b1, 1, 16'h0002);
    // R9 write in the search cycle: not seen until the next search
    @(negedge clk);
    wr_en = 1; wr_idx = 6; wr_data = 8'h34; search_go = 1;
    @(negedge clk);
    wr_en = 0; search_go = 0;
    expect_result("R9 old contents", 1'b1, 1, 16'h0002);
    search_only();
    expect_result("R9 new contents", 1'b1, 1, 16'h0042);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule